// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Shift Unit

This block is the combinational arithmetic unit of a small 8-bit processor. It takes two 8-bit operands, a 4-bit shift distance and a 3-bit operation code. It returns an 8-bit result, a flag that is high when the result is all zeros, and a carry flag. The same unit serves the register-register instructions and the immediate instructions. For the immediate forms the surrounding datapath places the 8-bit immediate on operand B.

The two equality branches (branch-if-equal and branch-if-not-equal) both use the subtract operation. They read only the zero flag, so one comparison serves both senses. Shifts act on operand A and ignore operand B. A shift distance from 8 to 15 clears the result.

Top module: `byte_alu`

## Requirements
- R1: Operation code 0 adds: result is the low 8 bits of opA + opB and carryFlag is bit 8 of that sum.
- R2: Operation code 1 subtracts as opA + ~opB + 1: result is opA - opB modulo 256 and carryFlag is 1 exactly when opA >= opB, meaning no borrow.
- R3: Operation code 2 returns opA AND opB bitwise and code 3 returns opA OR opB bitwise.
- R4: Operation code 4 returns the bitwise inverse of (opA OR opB) across all 8 bits.
- R5: Operation code 5 shifts opA left by shAmt for distances 0 to 7 and fills zeros from the right; opB has no effect.
- R6: Operation code 6 shifts opA right by shAmt for distances 0 to 7 and fills zeros from the left; opB has no effect.
- R7: For codes 5 and 6, any shAmt from 8 to 15 gives a result of 0x00.
- R8: zeroFlag is 1 exactly when result is 0x00, so a subtract of equal operands always raises it.
- R9: carryFlag is 0 for codes 2 to 6.
- R10: Operation code 7 is unused and gives result 0x00, zeroFlag 1 and carryFlag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aluOp | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 nor, 5 shift left, 6 shift right, 7 unused |
| opA | input | 8 | First operand; the value that is shifted |
| opB | input | 8 | Second operand, either a register or an immediate |
| shAmt | input | 4 | Shift distance, 0 to 15 |
| result | output | 8 | Operation result |
| zeroFlag | output | 1 | High when result is zero |
| carryFlag | output | 1 | Carry out of bit 7 for add and sub; low otherwise |

## Verification
The unit holds no state, so a decode or datapath fault shows at the outputs in the same cycle that the inputs settle. No history is needed to expose it. A wrong strobe from the decoder shows as a result that belongs to another operation. That is why each operation code is driven with operands whose answers differ between neighbouring operations. A fault in one barrel stage shows only for distances that use that stage. A fault in the range guard shows only for distances of 8 and above. The carry and zero flags are compared on every vector, so a flag that leaks into the wrong operation is caught on that vector.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_NOR  = 3'd4,
    OP_SLL  = 3'd5,
    OP_SRL  = 3'd6,
    OP_NONE = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_ADD   = 2'd1,
    SRC_LOGIC = 2'd2,
    SRC_SHIFT = 2'd3
  } resSrc_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2
  } logicOp_e;

  typedef struct packed {
    resSrc_e  resSrc;
    logic     invB;
    logicOp_e logicOp;
    logic     shLeft;
  } aluStrobes_t;

endpackage

// File: rtl/byte_alu_shift.sv
module byte_alu_shift #(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 4
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] shAmt,
  input  logic               shLeft,
  output logic [DATA_W-1:0]  dout
);

  localparam int STAGES = $clog2(DATA_W);
  localparam int USED_W = (SHAMT_W < STAGES) ? SHAMT_W : STAGES;

  logic              tooFar;
  logic [DATA_W-1:0] fwdIn;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] revOut;

  // A left shift is done as a right shift between two bit reversals.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign fwdIn[i]  = shLeft ? din[DATA_W-1-i] : din[i];
      assign revOut[i] = shifted[DATA_W-1-i];
    end
  endgenerate

  // Distance bits above the barrel range clear the result.
  generate
    if (SHAMT_W > STAGES) begin : g_guard
      assign tooFar = |shAmt[SHAMT_W-1:STAGES];
    end else begin : g_noguard
      assign tooFar = 1'b0;
    end
  endgenerate

  // Barrel stages: stage s moves the word by 2**s places.
  always_comb begin
    shifted = fwdIn;
    for (int s = 0; s < USED_W; s++) begin
      if (shAmt[s]) shifted = shifted >> (1 << s);
    end
  end

  always_comb begin
    if (tooFar)      dout = '0;
    else if (shLeft) dout = revOut;
    else             dout = shifted;
  end

endmodule

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic [2:0]  aluOp,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes = '{resSrc: SRC_ZERO, invB: 1'b0, logicOp: LG_AND, shLeft: 1'b0};
    unique case (aluOp_e'(aluOp))
      OP_ADD: strobes.resSrc = SRC_ADD;
      OP_SUB: begin
        strobes.resSrc = SRC_ADD;
        strobes.invB   = 1'b1;
      end
      OP_AND: begin
        strobes.resSrc  = SRC_LOGIC;
        strobes.logicOp = LG_AND;
      end
      OP_OR: begin
        strobes.resSrc  = SRC_LOGIC;
        strobes.logicOp = LG_OR;
      end
      OP_NOR: begin
        strobes.resSrc  = SRC_LOGIC;
        strobes.logicOp = LG_NOR;
      end
      OP_SLL: begin
        strobes.resSrc = SRC_SHIFT;
        strobes.shLeft = 1'b1;
      end
      OP_SRL: strobes.resSrc = SRC_SHIFT;
      default: strobes.resSrc = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/byte_alu_dp.sv
module byte_alu_dp
  import byte_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 4
) (
  input  aluStrobes_t        strobes,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shAmt,
  output logic [DATA_W-1:0]  result,
  output logic               zeroFlag,
  output logic               carryFlag
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] bEff;
  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] shiftRes;

  // One adder serves add and subtract; subtract inverts B and injects a carry.
  assign bEff = strobes.invB ? ~opB : opB;
  assign sum  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, strobes.invB};

  always_comb begin
    unique case (strobes.logicOp)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_NOR:  logicRes = ~(opA | opB);
      default: logicRes = '0;
    endcase
  end

  byte_alu_shift #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W)
  ) i_shift (
    .din   (opA),
    .shAmt (shAmt),
    .shLeft(strobes.shLeft),
    .dout  (shiftRes)
  );

  always_comb begin
    unique case (strobes.resSrc)
      SRC_ADD:   result = sum[DATA_W-1:0];
      SRC_LOGIC: result = logicRes;
      SRC_SHIFT: result = shiftRes;
      default:   result = '0;
    endcase
  end

  assign carryFlag = (strobes.resSrc == SRC_ADD) & sum[DATA_W];
  assign zeroFlag  = ~|result;

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 4
) (
  input  logic [2:0]         aluOp,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shAmt,
  output logic [DATA_W-1:0]  result,
  output logic               zeroFlag,
  output logic               carryFlag
);

  aluStrobes_t strobes;

  byte_alu_ctrl i_ctrl (
    .aluOp  (aluOp),
    .strobes(strobes)
  );

  byte_alu_dp #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W)
  ) i_dp (
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .shAmt    (shAmt),
    .result   (result),
    .zeroFlag (zeroFlag),
    .carryFlag(carryFlag)
  );

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 4
) (
  input logic [2:0]         aluOp,
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic [SHAMT_W-1:0] shAmt,
  input logic [DATA_W-1:0]  result,
  input logic               zeroFlag,
  input logic               carryFlag
);

  localparam int SUM_W = DATA_W + 1;

  logic known;
  assign known = !$isunknown({aluOp, opA, opB, shAmt});

  always_comb begin
    if (known) begin
      // R1
      add_sum_chk: assert (aluOp != 3'd0 ||
                           {carryFlag, result} == ({1'b0, opA} + {1'b0, opB}));
      // R2
      sub_borrow_chk: assert (aluOp != 3'd1 ||
                              (result == DATA_W'(opA - opB) && carryFlag == (opA >= opB)));
      // R4
      nor_disjoint_chk: assert (aluOp != 3'd4 ||
                                ((result & (opA | opB)) == '0 && (result | opA | opB) == '1));
      // R7
      wide_shift_chk: assert (!((aluOp == 3'd5 || aluOp == 3'd6) &&
                                32'(shAmt) >= DATA_W) || result == '0);
      // R8
      equal_cmp_chk: assert (!(aluOp == 3'd1 && opA == opB) || (zeroFlag && carryFlag));
      // R9
      no_carry_chk: assert (!(aluOp >= 3'd2 && aluOp <= 3'd6) || !carryFlag);
      // R10
      unused_op_chk: assert (aluOp != 3'd7 || (result == '0 && zeroFlag && !carryFlag));
    end
  end

endmodule

bind byte_alu byte_alu_chk #(
  .DATA_W (DATA_W),
  .SHAMT_W(SHAMT_W)
) i_byte_alu_chk (
  .aluOp    (aluOp),
  .opA      (opA),
  .opB      (opB),
  .shAmt    (shAmt),
  .result   (result),
  .zeroFlag (zeroFlag),
  .carryFlag(carryFlag)
);

// File: tb/test_byte_alu.sv
module test_byte_alu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] aluOp = 3'd0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [3:0] shAmt = 4'd0;
  logic [7:0] result;
  logic       zeroFlag;
  logic       carryFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  byte_alu i_byte_alu (
    .aluOp    (aluOp),
    .opA      (opA),
    .opB      (opB),
    .shAmt    (shAmt),
    .result   (result),
    .zeroFlag (zeroFlag),
    .carryFlag(carryFlag)
  );

  // Vector fields: {op[3], a[8], b[8], sh[4], res[8], zero[1], carry[1]}
  localparam int NVEC = 22;
  localparam logic [32:0] VEC [NVEC] = '{
    {3'd0, 8'h12, 8'h34, 4'd0,  8'h46, 1'b0, 1'b0},
    {3'd0, 8'hFF, 8'h01, 4'd0,  8'h00, 1'b1, 1'b1},
    {3'd0, 8'h80, 8'h90, 4'd0,  8'h10, 1'b0, 1'b1},
    {3'd1, 8'h50, 8'h20, 4'd0,  8'h30, 1'b0, 1'b1},
    {3'd1, 8'h20, 8'h50, 4'd0,  8'hD0, 1'b0, 1'b0},
    {3'd1, 8'h7A, 8'h7A, 4'd0,  8'h00, 1'b1, 1'b1},
    {3'd1, 8'h00, 8'h00, 4'd0,  8'h00, 1'b1, 1'b1},
    {3'd2, 8'hF0, 8'h3C, 4'd0,  8'h30, 1'b0, 1'b0},
    {3'd2, 8'hAA, 8'h55, 4'd0,  8'h00, 1'b1, 1'b0},
    {3'd3, 8'hA0, 8'h05, 4'd0,  8'hA5, 1'b0, 1'b0},
    {3'd4, 8'hA0, 8'h05, 4'd0,  8'h5A, 1'b0, 1'b0},
    {3'd4, 8'hFF, 8'h00, 4'd0,  8'h00, 1'b1, 1'b0},
    {3'd4, 8'h00, 8'h00, 4'd0,  8'hFF, 1'b0, 1'b0},
    {3'd5, 8'h81, 8'hFF, 4'd1,  8'h02, 1'b0, 1'b0},
    {3'd5, 8'h01, 8'h00, 4'd7,  8'h80, 1'b0, 1'b0},
    {3'd5, 8'hFF, 8'h00, 4'd8,  8'h00, 1'b1, 1'b0},
    {3'd6, 8'h81, 8'hFF, 4'd1,  8'h40, 1'b0, 1'b0},
    {3'd6, 8'h80, 8'h00, 4'd7,  8'h01, 1'b0, 1'b0},
    {3'd6, 8'hFF, 8'h00, 4'd15, 8'h00, 1'b1, 1'b0},
    {3'd6, 8'hB6, 8'h11, 4'd0,  8'hB6, 1'b0, 1'b0},
    {3'd5, 8'h3C, 8'h00, 4'd3,  8'hE0, 1'b0, 1'b0},
    {3'd7, 8'hFF, 8'hFF, 4'd5,  8'h00, 1'b1, 1'b0}
  };

  function automatic string tagOf(input logic [2:0] op, input logic [3:0] sh);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return (sh >= 4'd8) ? "R7" : "R5";
      3'd6: return (sh >= 4'd8) ? "R7" : "R6";
      default: return "R10";
    endcase
  endfunction

  // Reference model from the requirements: returns {res, zero, carry}.
  function automatic logic [9:0] model(input logic [2:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic [3:0] sh);
    logic [8:0] s;
    logic [7:0] r;
    logic       c;
    c = 1'b0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[7:0]; c = s[8]; end
      3'd1: begin r = a - b; c = (a >= b); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = ~(a | b);
      3'd5: r = (sh >= 4'd8) ? 8'h00 : (a << sh);
      3'd6: r = (sh >= 4'd8) ? 8'h00 : (a >> sh);
      default: r = 8'h00;
    endcase
    return {r, (r == 8'h00), c};
  endfunction

  task automatic drive(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [3:0] sh);
    @(posedge clk);
    aluOp = op; opA = a; opB = b; shAmt = sh;
    @(negedge clk);
  endtask

  task automatic expectAll(input string tag, input logic [7:0] r,
                           input logic z, input logic c);
    testsRun++;
    if (result !== r || zeroFlag !== z || carryFlag !== c) begin
      testsFailed++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h z=%b c=%b, expected res=%h z=%b c=%b",
               tag, aluOp, opA, opB, shAmt, result, zeroFlag, carryFlag, r, z, c);
    end
  endtask

  initial begin
    int cycles = 0;
    while (!finished && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [9:0] exp;
    logic [7:0] firstRes;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Reset state: all-zero inputs give add of zeros (R1, R8).
    @(negedge clk);
    expectAll("R1 reset-state", 8'h00, 1'b1, 1'b0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][32:30], VEC[v][29:22], VEC[v][21:14], VEC[v][13:10]);
      expectAll(tagOf(VEC[v][32:30], VEC[v][13:10]), VEC[v][9:2], VEC[v][1], VEC[v][0]);
    end

    // R8: equal operands under subtract always raise the zero flag.
    for (int a = 0; a < 256; a += 17) begin
      drive(3'd1, 8'(a), 8'(a), 4'd0);
      expectAll("R8 equal-compare", 8'h00, 1'b1, 1'b1);
    end

    // R5 / R6: opB has no effect on shifts.
    for (int k = 0; k < 2; k++) begin
      drive(3'(5 + k), 8'h5B, 8'h00, 4'd2);
      firstRes = result;
      drive(3'(5 + k), 8'h5B, 8'hFF, 4'd2);
      testsRun++;
      if (result !== firstRes) begin
        testsFailed++;
        $display("FAIL %s opB-ignored: got %h, expected %h", (k == 0) ? "R5" : "R6",
                 result, firstRes);
      end
    end

    // R7: every out-of-range distance clears both shift directions.
    for (int sh = 8; sh < 16; sh++) begin
      drive(3'd5, 8'hFF, 8'h00, 4'(sh));
      expectAll("R7 sll-wide", 8'h00, 1'b1, 1'b0);
      drive(3'd6, 8'hFF, 8'h00, 4'(sh));
      expectAll("R7 srl-wide", 8'h00, 1'b1, 1'b0);
    end

    // R9 / R10 and all others: sweep of operations against the model.
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [7:0] a;
      logic [7:0] b;
      logic [3:0] sh;
      op = 3'(i % 8);
      a  = 8'((i * 37 + 11) % 256);
      b  = 8'((i * 91 + 200) % 256);
      sh = 4'((i / 8) % 16);
      exp = model(op, a, b, sh);
      drive(op, a, b, sh);
      expectAll((op >= 3'd2 && op <= 3'd6) ? "R9 sweep" : tagOf(op, sh),
                exp[9:2], exp[1], exp[0]);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule